// File: doc/BRIEF.md
# Up-counting timer with trigger chaining

This block is a general-purpose 16-bit up-counter for timing and event generation. A prescaler divides the input clock, and the counter climbs from zero to a reload value, then wraps and emits a one-cycle update pulse. Both the prescaler and the reload value have a shadow stage, so software can change them mid-period without disturbing the period already in progress. Software can also force an immediate update.

The trigger output can chain timers together or start a conversion elsewhere. Its source is selected by an encoded master-mode field: a forced update, the run bit, the update event, a compare pulse, or one of four compare-reference inputs. On the input side, a slave controller picks one of four asynchronous trigger inputs. It can then let the counter run freely, gate it with the trigger level, start it on a trigger edge, or step it once per trigger edge.

All configuration goes through a narrow write/read register port. The counter value, the update pulse and the trigger output are also wired out directly.

Top module: `trig_timer`

## Requirements
- R1: After reset, the counter reads 0, update and trigger outputs are low, the control register reads 0, the reload register reads 0xFFFF, and the prescaler reads 0.
- R2: With control bit 0 (run) set and the slave mode off, the counter advances once every (prescaler+1) cycles. From the reload value it wraps to 0, and update_o is high for exactly the cycle in which the counter shows 0 after the wrap.
- R3: With control bit 1 (reload buffering) set, a write to the reload register (address 3) changes only its readback and takes effect at the next update event. With the bit clear, the write takes effect at once.
- R4: A write to the prescaler register (address 2) takes effect only at the next update event. The period in progress keeps its old tick rate.
- R5: Writing 1 to bit 0 of the event register (address 5) clears the counter and the prescaler phase, loads both shadow values, and pulses update_o in the next cycle, even while running.
- R6: The master-mode field (mode register, address 1, bits 2:0) selects trgo_o as follows:
  - 0: a one-cycle copy of a forced update.
  - 1: the run bit.
  - 2: the update pulse.
  - 3: the rising edge of cmp_ref_i[0].
  - 4 to 7: cmp_ref_i[0] to cmp_ref_i[3].
- R7: Trigger-select (mode bits 9:8) picks one of trig_i[3:0]. Only the selected input has any effect, and it passes through a two-flop synchronizer. A level change reaches the slave logic two cycles after the change is registered.
- R8: Slave mode 5 (mode bits 6:4) is gated. The counter advances only while the synchronized trigger is high and holds its value while the trigger is low.
- R9: Slave mode 6 is triggered. A rising edge of the synchronized trigger sets the run bit in hardware, which can be read back as control bit 0, and counting starts on the following cycle.
- R10: Slave mode 7 is external clock. With run set, the counter advances once per rising trigger edge, divided by the prescaler, however long the trigger stays high.
- R11: The count register (address 4) can be written while running. The written value replaces the next increment and can be read back.
- R12: Slave mode values 1 to 4 behave as slave mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| trig_i | input | 4 | Asynchronous trigger inputs |
| cmp_ref_i | input | 4 | Compare-reference levels for master mode |
| cnt_o | output | 16 | Counter value |
| update_o | output | 1 | Update event pulse |
| trgo_o | output | 1 | Trigger output |

## Verification
Faults in the prescaler phase or the active reload value show up as a counter that steps or wraps one or more cycles early or late. That deviation is visible on cnt_o within one period. A wrong shadow transfer appears only after the next update event, so the checks deliberately span two periods after each buffered write. A fault in the synchronizer or edge detector moves the first gated or triggered count by a cycle, and the bench samples exactly those cycles.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd5;

  localparam logic [2:0] SM_GATED = 3'd5;
  localparam logic [2:0] SM_TRIG  = 3'd6;
  localparam logic [2:0] SM_EXT   = 3'd7;

  localparam logic [2:0] MM_RESET  = 3'd0;
  localparam logic [2:0] MM_ENABLE = 3'd1;
  localparam logic [2:0] MM_UPDATE = 3'd2;
  localparam logic [2:0] MM_PULSE  = 3'd3;
endpackage

// File: rtl/trig_timer_sync.sv
module trig_timer_sync #(
  parameter int N_TRIG = 4,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              level_o,
  output logic              rise_o
);
  logic [N_TRIG-1:0] s1_q, s2_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= trig_i;
      s2_q   <= s1_q;
      prev_q <= level_o;
    end
  end

  assign level_o = s2_q[sel_i];
  assign rise_o  = level_o & ~prev_q;
endmodule

// File: rtl/trig_timer_presc.sv
module trig_timer_presc #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] phase_q;

  assign tick_o = en_i && (phase_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clr_i)   phase_q <= '0;
    else if (tick_o)  phase_q <= '0;
    else if (en_i)    phase_q <= phase_q + ONE;
  end
endmodule

// File: rtl/trig_timer_trgo.sv
module trig_timer_trgo
  import trig_timer_pkg::*;
#(
  parameter int N_CMP = 4,
  localparam int IDX_W = $clog2(N_CMP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       master_i,
  input  logic             ug_i,
  input  logic             run_i,
  input  logic             upd_i,
  input  logic [N_CMP-1:0] cmp_ref_i,
  output logic             trgo_o
);
  logic cmp0_prev_q;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp0_prev_q <= 1'b0;
    else         cmp0_prev_q <= cmp_ref_i[0];
  end

  assign idx = IDX_W'(master_i[1:0]);

  always_comb begin
    unique case (master_i)
      MM_RESET:  trgo_o = ug_i;
      MM_ENABLE: trgo_o = run_i;
      MM_UPDATE: trgo_o = upd_i;
      MM_PULSE:  trgo_o = cmp_ref_i[0] & ~cmp0_prev_q;
      default:   trgo_o = cmp_ref_i[idx];
    endcase
  end
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_TRIG = 4,
  parameter int N_CMP  = 4,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [N_CMP-1:0]  cmp_ref_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              update_o,
  output logic              trgo_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q, arpe_q, upd_q, ug_q;
  logic [2:0]       master_q, slave_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] psc_sh_q, psc_act_q, arr_sh_q, arr_act_q, cnt_q;
  logic             trig_lvl, trig_rise, tick, tick_src, wrap;
  logic             wr_ctrl, wr_mode, wr_psc, wr_rld, wr_cnt, force_upd;
  logic [CNT_W-1:0] mode_word;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_mode   = wr_en_i && (wr_addr_i == A_MODE);
  assign wr_psc    = wr_en_i && (wr_addr_i == A_PSC);
  assign wr_rld    = wr_en_i && (wr_addr_i == A_RLD);
  assign wr_cnt    = wr_en_i && (wr_addr_i == A_CNT);
  assign force_upd = wr_en_i && (wr_addr_i == A_EVT) && wr_data_i[0];

  trig_timer_sync #(.N_TRIG(N_TRIG)) u_sync (
    .clk_i, .rst_ni, .trig_i, .sel_i(sel_q),
    .level_o(trig_lvl), .rise_o(trig_rise)
  );

  always_comb begin
    unique case (slave_q)
      SM_GATED: tick_src = run_q & trig_lvl;
      SM_EXT:   tick_src = run_q & trig_rise;
      default:  tick_src = run_q;
    endcase
  end

  trig_timer_presc #(.W(CNT_W)) u_presc (
    .clk_i, .rst_ni, .clr_i(force_upd), .en_i(tick_src),
    .limit_i(psc_act_q), .tick_o(tick)
  );

  assign wrap = tick && (cnt_q == arr_act_q) && !wr_cnt && !force_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      arpe_q    <= 1'b0;
      master_q  <= '0;
      slave_q   <= '0;
      sel_q     <= '0;
      psc_sh_q  <= '0;
      psc_act_q <= '0;
      arr_sh_q  <= '1;
      arr_act_q <= '1;
      cnt_q     <= '0;
      upd_q     <= 1'b0;
      ug_q      <= 1'b0;
    end else begin
      upd_q <= force_upd | wrap;
      ug_q  <= force_upd;
      // software write wins over the hardware start
      if (wr_ctrl) begin
        run_q  <= wr_data_i[0];
        arpe_q <= wr_data_i[1];
      end else if (slave_q == SM_TRIG && trig_rise) begin
        run_q <= 1'b1;
      end
      if (wr_mode) begin
        master_q <= wr_data_i[2:0];
        slave_q  <= wr_data_i[6:4];
        sel_q    <= wr_data_i[8 +: SEL_W];
      end
      if (wr_psc) psc_sh_q <= wr_data_i;
      if (force_upd || wrap) psc_act_q <= psc_sh_q;
      if (force_upd || (wrap && arpe_q)) arr_act_q <= arr_sh_q;
      if (wr_rld) begin
        arr_sh_q <= wr_data_i;
        if (!arpe_q) arr_act_q <= wr_data_i;
      end
      if (force_upd)   cnt_q <= '0;
      else if (wr_cnt) cnt_q <= wr_data_i;
      else if (wrap)   cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + ONE;
    end
  end

  trig_timer_trgo #(.N_CMP(N_CMP)) u_trgo (
    .clk_i, .rst_ni, .master_i(master_q), .ug_i(ug_q), .run_i(run_q),
    .upd_i(upd_q), .cmp_ref_i, .trgo_o
  );

  always_comb begin
    mode_word = '0;
    mode_word[2:0] = master_q;
    mode_word[6:4] = slave_q;
    mode_word[8 +: SEL_W] = sel_q;
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = {{(CNT_W-2){1'b0}}, arpe_q, run_q};
      A_MODE:  rd_data_o = mode_word;
      A_PSC:   rd_data_o = psc_sh_q;
      A_RLD:   rd_data_o = arr_sh_q;
      A_CNT:   rd_data_o = cnt_q;
      default: rd_data_o = '0;
    endcase
  end

  assign cnt_o    = cnt_q;
  assign update_o = upd_q;
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             update_o,
  input logic             trgo_o,
  input logic             run,
  input logic [2:0]       slave,
  input logic [2:0]       master,
  input logic             lvl,
  input logic             rise
);
  AST_UPDATE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> cnt_o == '0);                                          // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_en_i) |=> $stable(cnt_o));                             // R2
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave == 3'd5 && !lvl && !wr_en_i) |=> $stable(cnt_o));            // R8
  AST_TRIG_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave == 3'd6 && rise && !wr_en_i) |=> run);                       // R9
  AST_EXT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave == 3'd7 && !rise && !wr_en_i) |=> $stable(cnt_o));           // R10
  AST_TRGO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master == 3'd1) |-> trgo_o == run);                                // R6
endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .cnt_o, .update_o, .trgo_o,
  .run(run_q), .slave(slave_q), .master(master_q),
  .lvl(trig_lvl), .rise(trig_rise)
);

// File: tb/trig_timer_test.sv
module trig_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_RD = 0, SEL_CNT = 1, SEL_TRG = 2, SEL_UPD = 3;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data, cnt;
  logic [3:0]  trig = '0, cmp = '0;
  logic        upd, trgo;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_timer uut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .trig_i(trig), .cmp_ref_i(cmp), .cnt_o(cnt), .update_o(upd),
    .trgo_o(trgo)
  );

  // monitor
  always @(negedge clk) begin
    cycles++;
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.sel)
        SEL_RD:  act = rd_data;
        SEL_CNT: act = cnt;
        SEL_TRG: act = {15'd0, trgo};
        default: act = {15'd0, upd};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
    if (cycles == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic chk(int sel, logic [15:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_rd(logic [2:0] a, logic [15:0] exp, string tag);
    rd_addr = a;
    chk(SEL_RD, exp, tag);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick();
    // R1
    chk(SEL_CNT, 0, "R1 cnt"); chk(SEL_TRG, 0, "R1 trgo");
    chk(SEL_UPD, 0, "R1 upd"); chk_rd(3, 16'hFFFF, "R1 reload");
    tick(); chk_rd(0, 0, "R1 ctrl");
    tick(); chk_rd(2, 0, "R1 psc");
    // R2 / R5
    wr(2, 2); wr(5, 1);
    chk(SEL_UPD, 1, "R5 upd"); chk(SEL_CNT, 0, "R5 cnt"); chk(SEL_TRG, 1, "R6 reset mode");
    wr(3, 3); wr(0, 1);
    tick(2); chk(SEL_CNT, 0, "R2 hold psc");
    tick(1); chk(SEL_CNT, 1, "R2 first step");
    tick(8); chk(SEL_CNT, 3, "R2 top"); chk(SEL_UPD, 0, "R2 no upd");
    tick(1); chk(SEL_CNT, 0, "R2 wrap"); chk(SEL_UPD, 1, "R2 upd");
    tick(1); chk(SEL_UPD, 0, "R2 upd one cycle");
    wr(0, 0);
    // R4
    wr(2, 0); wr(5, 1); wr(2, 1); wr(0, 1);
    chk(SEL_CNT, 0, "R4 start");
    tick(1); chk(SEL_CNT, 1, "R4 old rate");
    tick(3); chk(SEL_CNT, 0, "R4 wrap"); chk(SEL_UPD, 1, "R4 upd");
    tick(1); chk(SEL_CNT, 0, "R4 new rate hold");
    tick(1); chk(SEL_CNT, 1, "R4 new rate step");
    wr(0, 0);
    // R3
    wr(2, 0); wr(5, 1); wr(0, 2); wr(3, 1);
    chk_rd(3, 1, "R3 shadow readback");
    wr(0, 3);
    chk(SEL_CNT, 0, "R3 start");
    tick(2); chk(SEL_CNT, 2, "R3 old reload active");
    tick(2); chk(SEL_CNT, 0, "R3 wrap old"); chk(SEL_UPD, 1, "R3 upd");
    tick(1); chk(SEL_CNT, 1, "R3 new period");
    tick(1); chk(SEL_CNT, 0, "R3 wrap new"); chk(SEL_UPD, 1, "R3 upd new");
    wr(0, 0);
    // R11
    wr(3, 16'hFFFF); wr(5, 1); wr(0, 1); wr(4, 16'h1234);
    chk(SEL_CNT, 16'h1234, "R11 write");
    tick(1); chk(SEL_CNT, 16'h1235, "R11 continue"); chk_rd(4, 16'h1235, "R11 readback");
    // R6
    wr(1, 1); chk(SEL_TRG, 1, "R6 enable");
    wr(1, 2); wr(5, 1); chk(SEL_TRG, 1, "R6 update forced");
    wr(3, 2); chk(SEL_CNT, 1, "R6 cnt"); chk(SEL_TRG, 0, "R6 update low");
    tick(1); chk(SEL_CNT, 2, "R6 cnt top");
    tick(1); chk(SEL_TRG, 1, "R6 update wrap");
    wr(1, 3); cmp = 4'b0001; chk(SEL_TRG, 1, "R6 pulse");
    tick(1); chk(SEL_TRG, 0, "R6 pulse end");
    cmp = 4'b0100; wr(1, 6); chk(SEL_TRG, 1, "R6 ref3");
    wr(1, 5); chk(SEL_TRG, 0, "R6 ref2");
    cmp = 4'b0000; wr(0, 0);
    // R7 / R8
    trig = 4'b0010;
    wr(1, 16'h0250); wr(3, 100); wr(5, 1); wr(0, 1);
    tick(3); chk(SEL_CNT, 0, "R7 unselected input");
    trig = 4'b0110;
    tick(2); chk(SEL_CNT, 0, "R7 sync latency");
    tick(1); chk(SEL_CNT, 1, "R7 first gated step");
    tick(2); chk(SEL_CNT, 3, "R8 gated run");
    trig = 4'b0010;
    tick(3); chk(SEL_CNT, 5, "R8 gate drain");
    tick(2); chk(SEL_CNT, 5, "R8 gate hold");
    // R9
    wr(0, 0); trig = 4'b0000; tick(3);
    wr(1, 16'h0361); wr(5, 1);
    trig = 4'b1000;
    tick(2); chk_rd(0, 0, "R9 not yet"); chk(SEL_TRG, 0, "R9 trgo low");
    tick(1); chk_rd(0, 1, "R9 run set"); chk(SEL_TRG, 1, "R9 trgo high"); chk(SEL_CNT, 0, "R9 cnt");
    tick(1); chk(SEL_CNT, 1, "R9 counting");
    // R10
    wr(0, 0); wr(1, 16'h0370); trig = 4'b0000; tick(3);
    wr(5, 1); wr(0, 1);
    for (int k = 0; k < 3; k++) begin
      trig = 4'b1000; tick(3);
      trig = 4'b0000; tick(2);
    end
    tick(3); chk(SEL_CNT, 3, "R10 edge count");
    // R12
    wr(1, 16'h0320); wr(5, 1);
    chk(SEL_CNT, 0, "R5 force while running");
    tick(3); chk(SEL_CNT, 3, "R12 unlisted mode free run");
    tick(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule